// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank, four-bank synchronous DRAM with a 32-bit data bus from reset to a usable state. While reset is held, and for a fixed settling period after it is released, the block drives the idle (NOP) command. Clock enable and all four byte masks stay high for the whole run, so the memory keeps its data pins in high impedance.

When the settling period ends, the block issues one command to precharge all banks. It then loads the mode register with the word presented on `mode_word_i`, and then issues a configurable number of auto-refresh commands. After the spacing that follows the last refresh, the block raises `init_done_o` and leaves the command bus idle.

The settling period is `CLK_MHZ * STARTUP_US` clock cycles and is computed at elaboration. The idle gaps that follow the precharge, the mode-register load and each refresh are separate parameters. A controller built around this block holds off its own traffic until `init_done_o` is high.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_ni` is low, the command pins {cs_n, ras_n, cas_n, we_n} read 0111 (NOP), `cke_o` is 1, `dqm_o` is 4'b1111 and `init_done_o` is 0; a reset in mid-sequence returns the block to this state at once and restarts the sequence.
- R2: Let W = CLK_MHZ*STARTUP_US. Counting rising clock edges after reset release from 1, the first command other than NOP appears on the pins right after edge W, and every earlier cycle shows NOP.
- R3: `cke_o` is 1 and `dqm_o` is 4'b1111 in every cycle, both during and after the sequence.
- R4: The first command is PRECHARGE (0010), held for exactly one cycle, with address bit 10 set, every other address bit 0 and the bank address 0.
- R5: MODE REGISTER SET (0000) appears exactly T_RP edges after the precharge, for one cycle, with the address pins equal to `mode_word_i` and the bank address 0.
- R6: The first AUTO REFRESH (0001) appears exactly T_MRD edges after the mode register set; further refreshes follow every T_RC edges, and exactly REFRESH_COUNT refreshes are issued.
- R7: `init_done_o` rises exactly T_RC edges after the last refresh and never before the mode register set and all refreshes.
- R8: Once `init_done_o` is 1, it stays 1 until the next reset, and the command pins show NOP.
- R9: The command pins never carry any encoding other than 0111, 0010, 0001 or 0000, and every cycle not named in R4 to R7 is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_word_i | input | ADDR_W | Value loaded into the memory mode register |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable, held high |
| dqm_o | output | 4 | Byte data masks, held high |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address pins |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench computes the expected command, address and done value for every cycle from the parameters and compares them with the pins. It runs two configurations side by side: one with multi-cycle gaps and three refreshes, and one with every gap at a single cycle and two refreshes. An off-by-one in the settling counter or in any gap would shift a command by one cycle and be caught at that cycle. Ordering refresh before the mode load, or issuing one refresh too few or too many, breaks the per-cycle command pattern. The bench also resets the block in mid-sequence, which exposes a design whose counters or refresh tally are not cleared by reset: the rerun would put commands at the wrong cycles or finish early.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_STARTUP = 3'd0,
        ST_PRE_GAP = 3'd1,
        ST_MRS_GAP = 3'd2,
        ST_REF_GAP = 3'd3,
        ST_DONE    = 3'd4
    } init_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= RST_CNT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
(
    input  sdram_cmd_e cmd_i,
    output logic       cs_n_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o
);
    logic [3:0] pins;

    assign pins    = cmd_i;
    assign cs_n_o  = pins[3];
    assign ras_n_o = pins[2];
    assign cas_n_o = pins[1];
    assign we_n_o  = pins[0];

endmodule

// File: rtl/sdram_init_addr_gen.sv
module sdram_init_addr_gen
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned AP_BIT  = 10
) (
    input  sdram_cmd_e        cmd_i,
    input  logic [ADDR_W-1:0] mode_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        addr_o = '0;
        unique case (cmd_i)
            CMD_PRE: addr_o[AP_BIT] = 1'b1;   // all-bank precharge
            CMD_MRS: addr_o         = mode_i;
            default: addr_o         = '0;
        endcase
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 250,
    parameter int unsigned STARTUP_US    = 200,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned T_MRD         = 2,
    parameter int unsigned T_RC          = 9,
    parameter int unsigned REFRESH_COUNT = 2,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned DQM_W         = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] mode_word_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              cke_o,
    output logic [DQM_W-1:0]  dqm_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);
    localparam int unsigned WAIT_CYC = CLK_MHZ * STARTUP_US;
    localparam int unsigned GAP_MAX  = max_u(max_u(T_RP, T_MRD), T_RC);
    localparam int unsigned CNT_MAX  = max_u(WAIT_CYC, GAP_MAX);
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
    localparam int unsigned REF_W    = $clog2(REFRESH_COUNT + 1);

    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(T_RC - 1);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFRESH_COUNT - 1);

    typedef struct packed {
        init_state_e       state;
        sdram_cmd_e        cmd;
        logic [REF_W-1:0]  refs_left;
        logic [ADDR_W-1:0] mode;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state:     ST_STARTUP,
        cmd:       CMD_NOP,
        refs_left: '0,
        mode:      '0,
        done:      1'b0
    };

    seq_t             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    // One down-counter serves the settling wait and every idle gap
    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.cmd = CMD_NOP;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.state)
            ST_STARTUP: begin
                if (tmr_zero) begin
                    seq_d.cmd   = CMD_PRE;
                    seq_d.state = ST_PRE_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = RP_LOAD;
                end
            end
            ST_PRE_GAP: begin
                if (tmr_zero) begin
                    seq_d.cmd   = CMD_MRS;
                    seq_d.mode  = mode_word_i;
                    seq_d.state = ST_MRS_GAP;
                    tmr_load    = 1'b1;
                    tmr_val     = MRD_LOAD;
                end
            end
            ST_MRS_GAP: begin
                if (tmr_zero) begin
                    seq_d.cmd       = CMD_REF;
                    seq_d.refs_left = REF_LAST;
                    seq_d.state     = ST_REF_GAP;
                    tmr_load        = 1'b1;
                    tmr_val         = RC_LOAD;
                end
            end
            ST_REF_GAP: begin
                if (tmr_zero) begin
                    if (seq_q.refs_left == '0) begin
                        seq_d.state = ST_DONE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.cmd       = CMD_REF;
                        seq_d.refs_left = seq_q.refs_left - 1'b1;
                        tmr_load        = 1'b1;
                        tmr_val         = RC_LOAD;
                    end
                end
            end
            ST_DONE: begin
                seq_d.done = 1'b1;
            end
            default: begin
                seq_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    sdram_init_cmd_enc u_cmd_enc (
        .cmd_i   (seq_q.cmd),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o)
    );

    sdram_init_addr_gen #(
        .ADDR_W (ADDR_W),
        .AP_BIT (10)
    ) u_addr_gen (
        .cmd_i  (seq_q.cmd),
        .mode_i (seq_q.mode),
        .addr_o (addr_o)
    );

    assign cke_o       = 1'b1;
    assign dqm_o       = '1;
    assign ba_o        = '0;
    assign init_done_o = seq_q.done;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
    parameter int unsigned CLK_MHZ       = 250,
    parameter int unsigned STARTUP_US    = 200,
    parameter int unsigned REFRESH_COUNT = 2,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned DQM_W         = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic              cke_o,
    input logic [DQM_W-1:0]  dqm_o,
    input logic [BANK_W-1:0] ba_o,
    input logic              a10_i,
    input logic              init_done_o
);
    localparam int unsigned WAIT_CYC = CLK_MHZ * STARTUP_US;

    logic [3:0]  cmd;
    int unsigned since_rst;
    logic        seen_any, seen_pre, seen_mrs;
    int unsigned refs_seen;

    assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= 0;
            seen_any  <= 1'b0;
            seen_pre  <= 1'b0;
            seen_mrs  <= 1'b0;
            refs_seen <= 0;
        end else begin
            if (since_rst < WAIT_CYC) since_rst <= since_rst + 1;
            if (cmd != 4'b0111) seen_any <= 1'b1;
            if (cmd == 4'b0010) seen_pre <= 1'b1;
            if (cmd == 4'b0000) seen_mrs <= 1'b1;
            if (cmd == 4'b0001) refs_seen <= refs_seen + 1;
        end
    end

    AST_STARTUP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst < WAIT_CYC) |-> (cmd == 4'b0111)); // R2

    AST_PINS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cke_o && (&dqm_o)); // R3

    AST_FIRST_IS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd != 4'b0111 && !seen_any) |-> (cmd == 4'b0010 && a10_i && ba_o == '0)); // R4

    AST_MRS_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == 4'b0000) |-> (seen_pre && !seen_mrs && refs_seen == 0 && ba_o == '0)); // R5

    AST_REF_AFTER_MRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == 4'b0001) |-> (seen_mrs && refs_seen < REFRESH_COUNT)); // R6

    AST_DONE_NEEDS_REFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(init_done_o) |-> (seen_mrs && refs_seen == REFRESH_COUNT)); // R7

    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |=> init_done_o); // R8

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_done_o |-> (cmd == 4'b0111)); // R8

    AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd == 4'b0111 || cmd == 4'b0010 || cmd == 4'b0001 || cmd == 4'b0000)); // R9

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
    .CLK_MHZ       (CLK_MHZ),
    .STARTUP_US    (STARTUP_US),
    .REFRESH_COUNT (REFRESH_COUNT),
    .BANK_W        (BANK_W),
    .DQM_W         (DQM_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .cke_o       (cke_o),
    .dqm_o       (dqm_o),
    .ba_o        (ba_o),
    .a10_i       (addr_o[10]),
    .init_done_o (init_done_o)
);

// File: tb/sdram_powerup_seq_bench.sv
module sdram_powerup_seq_bench;

    // Configuration A: multi-cycle gaps, three refreshes
    localparam int A_MHZ = 1, A_US = 40, A_RP = 3, A_MRD = 2, A_RC = 4, A_N = 3;
    // Configuration B: every gap one cycle, two refreshes
    localparam int B_MHZ = 2, B_US = 13, B_RP = 1, B_MRD = 1, B_RC = 1, B_N = 2;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] mw_a = '0, mw_b = '0;

    logic a_cs, a_ras, a_cas, a_we, a_cke, a_done;
    logic [3:0] a_dqm;
    logic [1:0] a_ba;
    logic [AW-1:0] a_addr;
    logic b_cs, b_ras, b_cas, b_we, b_cke, b_done;
    logic [3:0] b_dqm;
    logic [1:0] b_ba;
    logic [AW-1:0] b_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdram_powerup_seq #(
        .CLK_MHZ(A_MHZ), .STARTUP_US(A_US), .T_RP(A_RP), .T_MRD(A_MRD),
        .T_RC(A_RC), .REFRESH_COUNT(A_N), .ADDR_W(AW)
    ) u_sdram_powerup_seq (
        .clk_i(clk), .rst_ni(rst_n), .mode_word_i(mw_a),
        .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we),
        .cke_o(a_cke), .dqm_o(a_dqm), .ba_o(a_ba), .addr_o(a_addr),
        .init_done_o(a_done)
    );

    sdram_powerup_seq #(
        .CLK_MHZ(B_MHZ), .STARTUP_US(B_US), .T_RP(B_RP), .T_MRD(B_MRD),
        .T_RC(B_RC), .REFRESH_COUNT(B_N), .ADDR_W(AW)
    ) u_sdram_powerup_seq_fast (
        .clk_i(clk), .rst_ni(rst_n), .mode_word_i(mw_b),
        .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we),
        .cke_o(b_cke), .dqm_o(b_dqm), .ba_o(b_ba), .addr_o(b_addr),
        .init_done_o(b_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected command for edge count e: 7 NOP, 2 PRE, 0 MRS, 1 REF
    function automatic logic [3:0] exp_cmd(input int e, input int w, input int rp,
                                           input int mrd, input int rc, input int n);
        int m, f;
        m = w + rp;
        f = m + mrd;
        if (e == w) return 4'b0010;
        if (e == m) return 4'b0000;
        if (e >= f && e < f + n * rc && ((e - f) % rc) == 0) return 4'b0001;
        return 4'b0111;
    endfunction

    task automatic check_one(input string tag, input int e, input int w, input int rp,
                             input int mrd, input int rc, input int n,
                             input logic [3:0] cmd, input logic cke, input logic [3:0] dqm,
                             input logic [1:0] ba, input logic [AW-1:0] addr,
                             input logic done, input logic [AW-1:0] mw);
        logic [3:0] ec;
        logic       ed;
        string      req;
        ec = exp_cmd(e, w, rp, mrd, rc, n);
        ed = (e >= w + rp + mrd + n * rc);
        if (e < w)                req = "R2";
        else if (ec == 4'b0010)   req = "R4";
        else if (ec == 4'b0000)   req = "R5";
        else if (ec == 4'b0001)   req = "R6";
        else if (ed)              req = "R8";
        else                      req = "R9";
        chk(cmd == ec, req, $sformatf("%s cmd e=%0d", tag, e), cmd, ec);
        chk(done == ed, "R7", $sformatf("%s done e=%0d", tag, e), done, ed);
        chk(cke == 1'b1 && dqm == 4'hF, "R3", $sformatf("%s cke/dqm e=%0d", tag, e),
            {cke, dqm}, 5'h1F);
        if (ec == 4'b0010) begin
            chk(addr == 12'h400 && ba == 2'b00, "R4", $sformatf("%s pre addr", tag),
                {ba, addr}, 14'h0400);
        end
        if (ec == 4'b0000) begin
            chk(addr == mw && ba == 2'b00, "R5", $sformatf("%s mrs addr", tag),
                {ba, addr}, {2'b00, mw});
        end
    endtask

    task automatic check_reset_state(input string when);
        chk({a_cs, a_ras, a_cas, a_we} == 4'b0111 && {b_cs, b_ras, b_cas, b_we} == 4'b0111,
            "R1", {when, " cmd"}, {a_cs, a_ras, a_cas, a_we, b_cs, b_ras, b_cas, b_we}, 8'h77);
        chk(a_cke && b_cke && a_dqm == 4'hF && b_dqm == 4'hF, "R1", {when, " cke/dqm"},
            {a_cke, a_dqm, b_cke, b_dqm}, 10'h3FF);
        chk(!a_done && !b_done, "R1", {when, " done"}, {a_done, b_done}, 0);
    endtask

    // Release reset at a negedge, then check every cycle for the given span
    task automatic run_seq(input int cycles, input logic [AW-1:0] wa, input logic [AW-1:0] wb);
        mw_a = wa;
        mw_b = wb;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e <= cycles; e++) begin
            check_one("A", e, A_MHZ * A_US, A_RP, A_MRD, A_RC, A_N,
                      {a_cs, a_ras, a_cas, a_we}, a_cke, a_dqm, a_ba, a_addr, a_done, wa);
            check_one("B", e, B_MHZ * B_US, B_RP, B_MRD, B_RC, B_N,
                      {b_cs, b_ras, b_cas, b_we}, b_cke, b_dqm, b_ba, b_addr, b_done, wb);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        check_reset_state("hold");

        // Full run, distinct mode words
        run_seq(70, 12'h5A3, 12'h0C6);

        // R1: reset mid-sequence, near A's mode load and after B is done
        rst_n = 1'b0;
        #1;
        check_reset_state("async");
        @(negedge clk);
        check_reset_state("mid");
        run_seq(42, 12'hFFF, 12'h800);

        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("second");

        // Full rerun after restart with new words
        run_seq(70, 12'h237, 12'hA81);

        finish_run();
    end

endmodule